// File: doc/BRIEF.md
# Strobe-Pair GPIO Control Register

This block is a single 32-bit register that drives and senses up to eight general-purpose pins. Each pin owns two bit pairs in the word. The low pair carries a set strobe and a clear strobe for the output level. The high pair carries an enable strobe and a disable strobe for the output driver. A write acts only where a strobe bit is 1, so software can change one pin with a single full-word store, and it never has to read, merge and write back the register.

Reading the word returns the direction flag and the output latch for each pin. For a pin in input mode it also returns the level sampled from the pin. Pin inputs pass through a two-flop synchroniser before they reach readback. To toggle an output, software reads the latch bit and then writes either the clear strobe or the set strobe. The same RTL serves a smaller instance that uses only some of the pin slots. In that instance the unused slots read as zero and ignore writes.

Top module: `sc_gpio_reg`

## Requirements
- R1: After reset, every pin is an input with its output latch at 0: `pin_out_o` = 0, `pin_oe_o` = 0, and `rd_data_o` = 0 while the synchronised inputs are 0.
- R2: A write with bit 2n+1 set (and bit 2n clear) sets the output latch of pin n. `pin_out_o[n]` shows the change one clock after the write edge.
- R3: A write with bit 2n set clears the output latch of pin n on the write edge.
- R4: A write with bit 16+2n set turns on the output driver of pin n (`pin_oe_o[n]`=1). Bit 17+2n turns it off.
- R5: Strobe bits written as 0 have no effect. A write changes only the pins whose strobe bits are 1.
- R6: If bits 2n and 2n+1 are both 1 in one write, the latch is cleared. If bits 16+2n and 17+2n are both 1, the driver is turned off.
- R7: Readback places the output latch of pin n at bit 2n and its direction flag (1 = output) at bit 16+2n. Bit 17+2n always reads 0.
- R8: When pin n is an input, bit 2n+1 reads the synchronised pin level. When it is an output, bit 2n+1 reads 0.
- R9: Pin slots at index NUM_PINS and above read as 0 in all four bit positions, and writes to them have no effect.
- R10: A toggle works as follows: read bit 2n, then write the clear strobe if it was 1 and the set strobe otherwise. This inverts the latch of pin n.
- R11: While `wr_en_i` is 0, the latches and direction flags hold their values whatever `wr_data_i` carries.
- R12: A change on `pin_in_i[n]` appears in bit 2n+1 of readback after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the register word |
| wr_data_i | input | 32 | Word of set/clear and enable/disable strobes |
| rd_data_o | output | 32 | Readback word: latch, input level, direction |
| pin_in_i | input | NUM_PINS | Raw pin levels, asynchronous |
| pin_out_o | output | NUM_PINS | Output level latch per pin |
| pin_oe_o | output | NUM_PINS | Output driver enable per pin |

## Verification
The bench builds two copies of the block on the same write bus. One has NUM_PINS = 8, so every bit of the word is live. The other has NUM_PINS = 4, so the upper slots exist but must stay silent. Feeding both copies the same random strobe words makes the check of unused slots and write isolation (R9) happen on every cycle, alongside the full eight-pin decode. Directed sequences cover the two-edge input latency, strobe collisions and the read-then-write toggle.

// File: rtl/sc_gpio_pkg.sv
package sc_gpio_pkg;

  localparam int unsigned REG_W    = 32;
  localparam int unsigned HALF_W   = REG_W / 2;
  localparam int unsigned MAX_PINS = HALF_W / 2;

  typedef struct packed {
    logic lvl_set;
    logic lvl_clr;
    logic drv_on;
    logic drv_off;
  } pin_cmd_t;

  function automatic int unsigned lvl_clr_pos(int unsigned n);
    return 2 * n;
  endfunction

  function automatic int unsigned lvl_set_pos(int unsigned n);
    return 2 * n + 1;
  endfunction

  function automatic int unsigned drv_on_pos(int unsigned n);
    return HALF_W + 2 * n;
  endfunction

  function automatic int unsigned drv_off_pos(int unsigned n);
    return HALF_W + 2 * n + 1;
  endfunction

  function automatic pin_cmd_t pick_cmd(logic [REG_W-1:0] w, int unsigned n);
    pin_cmd_t c;
    c.lvl_set = w[lvl_set_pos(n)];
    c.lvl_clr = w[lvl_clr_pos(n)];
    c.drv_on  = w[drv_on_pos(n)];
    c.drv_off = w[drv_off_pos(n)];
    return c;
  endfunction

  // Clear beats set when both are present.
  function automatic logic next_level(logic cur, logic s, logic c);
    return c ? 1'b0 : (s ? 1'b1 : cur);
  endfunction

endpackage

// File: rtl/sc_gpio_wdec.sv
module sc_gpio_wdec
  import sc_gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                     wr_en_i,
  input  logic [REG_W-1:0]         wr_data_i,
  output pin_cmd_t [NUM_PINS-1:0]  cmd_o
);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign cmd_o[g] = wr_en_i ? pick_cmd(wr_data_i, g) : '0;
  end

endmodule

// File: rtl/sc_gpio_pin_cell.sv
module sc_gpio_pin_cell
  import sc_gpio_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pin_cmd_t cmd_i,
  output logic     lvl_q_o,
  output logic     drv_q_o
);

  logic lvl_q, drv_q;
  logic lvl_d, drv_d;

  assign lvl_d = next_level(lvl_q, cmd_i.lvl_set, cmd_i.lvl_clr);
  assign drv_d = next_level(drv_q, cmd_i.drv_on, cmd_i.drv_off);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      drv_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      drv_q <= drv_d;
    end
  end

  assign lvl_q_o = lvl_q;
  assign drv_q_o = drv_q;

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.lvl_set && !cmd_i.lvl_clr) |=> lvl_q_o);
  p_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.lvl_clr |=> !lvl_q_o);
  p_drv_on_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.drv_on && !cmd_i.drv_off) |=> drv_q_o);
  p_drv_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.drv_off |=> !drv_q_o);
  p_lvl_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_i.lvl_set && !cmd_i.lvl_clr) |=> $stable(lvl_q_o));
  p_drv_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_i.drv_on && !cmd_i.drv_off) |=> $stable(drv_q_o));

endmodule

// File: rtl/sc_gpio_sync.sv
module sc_gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    logic [1:0] age_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         age_q <= '0;
      else if (age_q != 2) age_q <= age_q + 2'd1;
    end
    p_two_edge_latency_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == 2'd2) |-> (sync_o == $past(async_i, 2)));
  end

endmodule

// File: rtl/sc_gpio_rdmux.sv
module sc_gpio_rdmux
  import sc_gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] drv_i,
  input  logic [NUM_PINS-1:0] smp_i,
  output logic [REG_W-1:0]    rd_o
);

  always_comb begin
    rd_o = '0;
    for (int unsigned n = 0; n < NUM_PINS; n++) begin
      rd_o[lvl_clr_pos(n)] = lvl_i[n];
      rd_o[lvl_set_pos(n)] = smp_i[n] & ~drv_i[n];
      rd_o[drv_on_pos(n)]  = drv_i[n];
    end
  end

endmodule

// File: rtl/sc_gpio_reg.sv
module sc_gpio_reg
  import sc_gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [31:0]         wr_data_i,
  output logic [31:0]         rd_data_o,
  input  logic [NUM_PINS-1:0] pin_in_i,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_oe_o
);

  localparam logic [REG_W-1:0] OFF_MASK = {MAX_PINS{2'b10, {HALF_W/MAX_PINS{1'b0}}}} >> 0;

  pin_cmd_t [NUM_PINS-1:0] cmd;
  logic [NUM_PINS-1:0]     smp;

  sc_gpio_wdec #(.NUM_PINS(NUM_PINS)) u_wdec (
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cmd_o     (cmd)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_cell
    sc_gpio_pin_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cmd_i   (cmd[g]),
      .lvl_q_o (pin_out_o[g]),
      .drv_q_o (pin_oe_o[g])
    );
  end

  sc_gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_in_i),
    .sync_o  (smp)
  );

  sc_gpio_rdmux #(.NUM_PINS(NUM_PINS)) u_rdmux (
    .lvl_i (pin_out_o),
    .drv_i (pin_oe_o),
    .smp_i (smp),
    .rd_o  (rd_data_o)
  );

  // Odd bits of the upper half: the disable positions.
  logic [REG_W-1:0] off_pos_mask;
  always_comb begin
    off_pos_mask = '0;
    for (int unsigned n = 0; n < MAX_PINS; n++) off_pos_mask[drv_off_pos(n)] = 1'b1;
  end

  p_off_reads_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & off_pos_mask) == '0);
  p_wr_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(pin_out_o) && $stable(pin_oe_o)));
  p_reset_state_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (pin_oe_o == '0));

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
    p_out_pin_in_bit_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pin_oe_o[g] |-> !rd_data_o[2*g+1]);
    p_dir_readback_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_data_o[HALF_W+2*g] == pin_oe_o[g]);
  end

  if (NUM_PINS < MAX_PINS) begin : g_unused_chk
    p_unused_slots_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_data_o[HALF_W-1:2*NUM_PINS] == '0) &&
      (rd_data_o[REG_W-1:HALF_W+2*NUM_PINS] == '0));
  end

  logic unused_mask;
  assign unused_mask = ^OFF_MASK;

endmodule

// File: tb/sc_gpio_reg_tb.sv
module sc_gpio_reg_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [7:0]  pin_in = '0;
  logic [31:0] rd_f, rd_h;
  logic [7:0]  out_f, oe_f;
  logic [3:0]  out_h, oe_h;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_out_f = '0, m_oe_f = '0;
  logic [7:0] m_out_h = '0, m_oe_h = '0;

  always #2.5 clk = ~clk;

  sc_gpio_reg #(.NUM_PINS(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_f), .pin_in_i(pin_in), .pin_out_o(out_f), .pin_oe_o(oe_f)
  );

  sc_gpio_reg #(.NUM_PINS(4)) u_dut_half (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_h), .pin_in_i(pin_in[3:0]), .pin_out_o(out_h), .pin_oe_o(oe_h)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Readback per the requirements: latch at 2n, input at 2n+1 only in
  // input mode, direction at 16+2n, nothing at 17+2n.
  function automatic logic [31:0] want_rd(logic [7:0] o, logic [7:0] e,
                                          logic [7:0] i, int np);
    logic [31:0] r = '0;
    for (int n = 0; n < np; n++) begin
      r[2*n]      = o[n];
      r[2*n+1]    = i[n] && !e[n];
      r[16+2*n]   = e[n];
    end
    return r;
  endfunction

  task automatic model_write(logic [31:0] w);
    for (int n = 0; n < 8; n++) begin
      if (w[2*n]) m_out_f[n] = 1'b0; else if (w[2*n+1]) m_out_f[n] = 1'b1;
      if (w[17+2*n]) m_oe_f[n] = 1'b0; else if (w[16+2*n]) m_oe_f[n] = 1'b1;
      if (n < 4) begin
        m_out_h[n] = m_out_f[n];
        m_oe_h[n]  = m_oe_f[n];
      end
    end
  endtask

  task automatic bus_write(logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = $urandom;
    model_write(w);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic check_all(string req);
    check({req, " rd8"}, rd_f, want_rd(m_out_f, m_oe_f, pin_in, 8));
    check({req, " out8"}, {24'h0, out_f}, {24'h0, m_out_f});
    check({req, " oe8"}, {24'h0, oe_f}, {24'h0, m_oe_f});
    check({req, " rd4"}, rd_h, want_rd(m_out_h, m_oe_h, pin_in, 4));
    check({req, " out4"}, {28'h0, out_h}, {28'h0, m_out_h[3:0]});
    check({req, " oe4"}, {28'h0, oe_h}, {28'h0, m_oe_h[3:0]});
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic b;
    void'($urandom(32'd1234));
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check_all("R1 reset");

    bus_write(32'h0000_0008); idle(1); check_all("R2 set pin1");
    check("R2 pin1 high", {31'h0, out_f[1]}, 32'h1);
    bus_write(32'h0000_0004); idle(1); check_all("R3 clear pin1");
    bus_write(32'h0001_0000); idle(1); check_all("R4 enable pin0");
    bus_write(32'h0002_0000); idle(1); check_all("R4 disable pin0");
    bus_write(32'h0000_8000); idle(1); check_all("R5 set pin7 only");
    bus_write(32'h0000_0000); idle(1); check_all("R5 zero word");
    bus_write(32'h0000_0030); idle(1); check_all("R6 set+clear pin2");
    check("R6 clear wins", {31'h0, out_f[2]}, 32'h0);
    bus_write(32'h0030_0000); idle(1); check_all("R6 en+dis pin2");
    check("R6 disable wins", {31'h0, oe_f[2]}, 32'h0);

    // R11: junk on the data bus while write enable is low.
    @(negedge clk); wr_data = 32'hFFFF_AAAA; idle(3); check_all("R11 no write");

    // R9: every strobe on the four-pin copy's unused slots.
    bus_write(32'h5555_AAAA); idle(1); check_all("R9 set all enable all");
    check("R9 upper slots zero", rd_h & 32'hFF00_FF00, 32'h0);
    bus_write(32'hAAAA_5555); idle(1); check_all("R9 clear all disable all");

    // R12: input latency on pin 5 in input mode.
    pin_in = 8'h00; idle(4);
    @(negedge clk); pin_in[5] = 1'b1;
    @(posedge clk); #1;
    check("R12 after one edge", {31'h0, rd_f[11]}, 32'h0);
    @(posedge clk); #1;
    check("R12 after two edges", {31'h0, rd_f[11]}, 32'h1);
    idle(1); check_all("R8 input readback");
    bus_write(32'h0400_0000); idle(1); check_all("R8 output hides input");

    // R10: toggle pin 6 twice by read then write.
    for (int t = 0; t < 2; t++) begin
      b = rd_f[12];
      bus_write(b ? 32'h0000_1000 : 32'h0000_2000);
      idle(1);
      check("R10 toggle", {31'h0, out_f[6]}, {31'h0, ~b});
      check_all("R10 toggle state");
    end

    for (int it = 0; it < 400; it++) begin
      if (it % 8 == 0) w = $urandom;
      else w = $urandom & $urandom & $urandom;
      pin_in = 8'($urandom);
      bus_write(w);
      idle(3);
      check_all("R5 R7 R8 R9 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule